// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block handles the control side of taking and leaving exceptions in a 16/32-bit processor core. A request can come from an external source with its own vector number. It can also be a trace event, raised when an instruction finishes while the trace bit is set. It can also be a privilege violation, raised when a privileged operation is attempted in user state. For any of these, the sequencer first saves the return address and the current status word on the supervisor stack, in three 16-bit writes. It then switches the core into supervisor state and reads the two halves of the handler address from the table slot at vector × 4. Finally it hands that address to the program counter.

A return request runs the reverse sequence. It pops the status word and the two halves of the return address, restores both, and lets the restored supervisor bit choose the active stack pointer again. The block keeps two banked stack pointers. The supervisor bit selects which one the core sees. In supervisor state the user copy can also be reached through a select input. The block has no decoder and no ALU. Instruction completion, privileged-opcode attempts and return requests reach it as single-cycle strobes. Memory traffic goes through a word-wide request/acknowledge port, and the request is held until it is acknowledged.

Top module: `exc_seq`

## Requirements
- R1: After reset, `sr_out` is 0x2700 and `busy` is 0. The status word layout is: T at bit 15, S at bit 13, the 3-bit interrupt mask at bits 10:8, and X,N,Z,V,C at bits 4:0. `a7_rdata` shows the supervisor stack pointer's reset value, 0x1000.
- R2: An exception entry writes three words on the memory port. The return address low half goes to SP-2, the high half to SP-4, and the status word to SP-6, where SP is the supervisor stack pointer. SP then ends at SP-6.
- R3: The status word that is pushed is the value from before the exception. After entry, S is 1 and T is 0. The mask and condition bits are unchanged.
- R4: After the pushes, the block reads the high half of the handler address from vector×4 and the low half from vector×4+2. It then raises `pc_load` for exactly one cycle with the combined 32-bit value on `pc_value`, and returns to idle.
- R5: `a7_rdata` and `a7_we` act on the supervisor copy when S=1 and on the user copy when S=0.
- R6: With S=1 and `usp_acc`=1, reads and writes go to the user copy. With S=0, no write reaches the supervisor copy.
- R7: An `instr_done` strobe while T=1 starts an entry with vector 9, using `ret_pc` as the return address.
- R8: A `priv_attempt` strobe while S=0 starts an entry with vector 8. If it arrives in the same cycle as a trace event, only the vector-8 entry runs.
- R9: A `rte_req` strobe while S=1 reads the status word at SP, the return address high half at SP+2 and the low half at SP+4. It then sets SP to SP+6, restores the status word, and loads the return address through `pc_load`. If the restored S is 0, `a7_rdata` then shows the user copy.
- R10: A `rte_req` strobe while S=0 pops nothing and starts a vector-8 entry instead.
- R11: A memory request keeps its address, direction and data until `mem_ack`. While `busy` is 1, request strobes and `sr_wr` are ignored.
- R12: A `sr_wr` while idle loads the status word. Bits outside those listed in R1 always read 0.
- R13: `exc_req` starts an entry with `exc_vec`. When several requests arrive together, the priority is: privilege violation first, then trace, then external request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | External exception request strobe |
| exc_vec | input | 8 | Vector number for the external request |
| priv_attempt | input | 1 | A privileged operation was attempted |
| rte_req | input | 1 | Return-from-exception strobe |
| instr_done | input | 1 | An instruction has completed |
| ret_pc | input | 32 | Return address to save for the request |
| sr_wr | input | 1 | Load the status word (idle only) |
| sr_wdata | input | 16 | Status word to load |
| sr_out | output | 16 | Current status word |
| a7_we | input | 1 | Write the selected stack pointer |
| a7_wdata | input | 32 | Stack pointer write value |
| usp_acc | input | 1 | In supervisor state, select the user copy |
| a7_rdata | output | 32 | Selected stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| pc_load | output | 1 | Load the program counter this cycle |
| pc_value | output | 32 | New program counter value |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest situation to reach is the handover between banks. This happens when a return restores S=0, or when an exception arrives in user state. There the supervisor copy must keep a value that the user side cannot reach, and the active copy must switch on the same edge as the status word. The stimulus moves the core into user state with a status write. It then changes the user copy through the normal write path and runs entries from user state, caused by a privilege violation, a return attempt and a trace event. The addresses checked for each push and pop then show that the supervisor copy was left untouched. Strobes that arrive together, and strobes sent during a sequence that is held up by wait states, show the priority order and that requests are ignored while busy.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int DW   = 16;
    localparam int PC_W = 2 * DW;

    localparam logic [DW-1:0] SR_RESET = 16'h2700;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_FETCH,
        ST_POP,
        ST_LOAD
    } seq_state_t;

    typedef struct packed {
        logic       t;
        logic       rsv14;
        logic       s;
        logic [1:0] rsv12;
        logic [2:0] mask;
        logic [2:0] rsv7;
        logic [4:0] ccr;
    } stat_t;

    function automatic stat_t stat_clean(input logic [DW-1:0] w);
        stat_t r;
        r       = stat_t'(w);
        r.rsv14 = 1'b0;
        r.rsv12 = 2'b00;
        r.rsv7  = 3'b000;
        return r;
    endfunction

endpackage

// File: rtl/exc_arb.sv
module exc_arb #(
    parameter int VEC_W     = 8,
    parameter int VEC_PRIV  = 8,
    parameter int VEC_TRACE = 9
) (
    input  logic             idle,
    input  logic             s_bit,
    input  logic             t_bit,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             priv_attempt,
    input  logic             rte_req,
    input  logic             instr_done,
    output logic             start_entry,
    output logic             start_rte,
    output logic [VEC_W-1:0] vec
);
    logic priv_hit, rte_ok, trace_hit, ext_hit;

    always_comb begin
        priv_hit  = idle && !s_bit && (priv_attempt || rte_req);
        rte_ok    = idle && s_bit && rte_req;
        trace_hit = idle && instr_done && t_bit;
        ext_hit   = idle && exc_req;

        start_entry = 1'b0;
        start_rte   = 1'b0;
        vec         = '0;
        if (priv_hit) begin
            start_entry = 1'b1;
            vec         = VEC_W'(VEC_PRIV);
        end else if (rte_ok) begin
            start_rte = 1'b1;
        end else if (trace_hit) begin
            start_entry = 1'b1;
            vec         = VEC_W'(VEC_TRACE);
        end else if (ext_hit) begin
            start_entry = 1'b1;
            vec         = exc_vec;
        end
    end
endmodule

// File: rtl/exc_sp_bank.sv
module exc_sp_bank #(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] SSP_INIT = 32'h0000_1000,
    parameter logic [AW-1:0] USP_INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_bit,
    input  logic          usp_acc,
    input  logic          a7_we,
    input  logic [AW-1:0] a7_wdata,
    input  logic          seq_we,
    input  logic [AW-1:0] seq_wdata,
    output logic [AW-1:0] a7_rdata,
    output logic [AW-1:0] ssp_q
);
    logic [AW-1:0] usp_q;
    logic          pick_ssp;

    assign pick_ssp = s_bit && !usp_acc;
    assign a7_rdata = pick_ssp ? ssp_q : usp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ssp_q <= SSP_INIT;
            usp_q <= USP_INIT;
        end else if (seq_we) begin
            ssp_q <= seq_wdata;
        end else if (a7_we) begin
            if (pick_ssp) ssp_q <= a7_wdata;
            else          usp_q <= a7_wdata;
        end
    end

    // R6
    ssp_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (!s_bit && !seq_we) |=> $stable(ssp_q));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            VEC_W     = 8,
    parameter int            VEC_PRIV  = 8,
    parameter int            VEC_TRACE = 9,
    parameter logic [AW-1:0] SSP_INIT  = 32'h0000_1000,
    parameter logic [AW-1:0] USP_INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             priv_attempt,
    input  logic             rte_req,
    input  logic             instr_done,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic             sr_wr,
    input  logic [DW-1:0]    sr_wdata,
    output logic [DW-1:0]    sr_out,
    input  logic             a7_we,
    input  logic [AW-1:0]    a7_wdata,
    input  logic             usp_acc,
    output logic [AW-1:0]    a7_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_value,
    output logic             busy
);
    localparam logic [1:0] LAST_STEP = 2'd2;

    seq_state_t     state;
    logic [1:0]     step;
    stat_t          sr_q, wsr;
    logic [PC_W-1:0] wpc;
    logic [AW-1:0]  base, ssp_q;
    logic [VEC_W-1:0] wvec, arb_vec;
    logic           idle, start_entry, start_rte, seq_we, last_ack;
    logic [AW-1:0]  seq_wdata;

    assign idle     = (state == ST_IDLE);
    assign busy     = !idle;
    assign sr_out   = sr_q;
    assign pc_load  = (state == ST_LOAD);
    assign pc_value = wpc;
    assign last_ack = mem_ack && (step == LAST_STEP);

    exc_arb #(.VEC_W(VEC_W), .VEC_PRIV(VEC_PRIV), .VEC_TRACE(VEC_TRACE)) u_arb (
        .idle(idle), .s_bit(sr_q.s), .t_bit(sr_q.t),
        .exc_req(exc_req), .exc_vec(exc_vec), .priv_attempt(priv_attempt),
        .rte_req(rte_req), .instr_done(instr_done),
        .start_entry(start_entry), .start_rte(start_rte), .vec(arb_vec)
    );

    always_comb begin
        seq_we    = 1'b0;
        seq_wdata = base;
        if (state == ST_PUSH && last_ack) begin
            seq_we    = 1'b1;
            seq_wdata = base - AW'(6);
        end else if (state == ST_POP && last_ack) begin
            seq_we    = 1'b1;
            seq_wdata = base + AW'(6);
        end
    end

    exc_sp_bank #(.AW(AW), .SSP_INIT(SSP_INIT), .USP_INIT(USP_INIT)) u_sp (
        .clk(clk), .rst(rst), .s_bit(sr_q.s), .usp_acc(usp_acc),
        .a7_we(a7_we), .a7_wdata(a7_wdata), .seq_we(seq_we), .seq_wdata(seq_wdata),
        .a7_rdata(a7_rdata), .ssp_q(ssp_q)
    );

    // memory request decode
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = base - AW'({step, 1'b0}) - AW'(2);
                case (step)
                    2'd0:    mem_wdata = wpc[DW-1:0];
                    2'd1:    mem_wdata = wpc[PC_W-1:DW];
                    default: mem_wdata = wsr;
                endcase
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = (AW'(wvec) << 2) + AW'({step[0], 1'b0});
            end
            ST_POP: begin
                mem_req  = 1'b1;
                mem_addr = base + AW'({step, 1'b0});
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            sr_q  <= stat_t'(SR_RESET);
            wsr   <= '0;
            wpc   <= '0;
            base  <= '0;
            wvec  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    step <= '0;
                    if (start_entry) begin
                        state  <= ST_PUSH;
                        wpc    <= ret_pc;
                        wsr    <= sr_q;
                        wvec   <= arb_vec;
                        base   <= ssp_q;
                        sr_q.s <= 1'b1;
                        sr_q.t <= 1'b0;
                    end else if (start_rte) begin
                        state <= ST_POP;
                        base  <= ssp_q;
                    end else if (sr_wr) begin
                        sr_q <= stat_clean(sr_wdata);
                    end
                end
                ST_PUSH: if (mem_ack) begin
                    if (step == LAST_STEP) begin
                        state <= ST_FETCH;
                        step  <= '0;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                ST_FETCH: if (mem_ack) begin
                    if (step == 2'd0) begin
                        wpc[PC_W-1:DW] <= mem_rdata;
                        step <= 2'd1;
                    end else begin
                        wpc[DW-1:0] <= mem_rdata;
                        state <= ST_LOAD;
                    end
                end
                ST_POP: if (mem_ack) begin
                    case (step)
                        2'd0:    wsr <= stat_clean(mem_rdata);
                        2'd1:    wpc[PC_W-1:DW] <= mem_rdata;
                        default: begin
                            wpc[DW-1:0] <= mem_rdata;
                            sr_q  <= wsr;
                            state <= ST_LOAD;
                        end
                    endcase
                    step <= step + 2'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3
    entry_super_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && start_entry) |=> (sr_out[13] && !sr_out[15]));

    // R4
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (!pc_load && !busy));

    // R11
    busy_sr_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !(state == ST_POP && mem_ack)) |=> $stable(sr_out));
endmodule

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 0, priv_attempt = 0, rte_req = 0, instr_done = 0;
    logic [7:0]  exc_vec = 0;
    logic [31:0] ret_pc = 0;
    logic        sr_wr = 0;
    logic [15:0] sr_wdata = 0;
    logic [15:0] sr_out;
    logic        a7_we = 0, usp_acc = 0;
    logic [31:0] a7_wdata = 0, a7_rdata;
    logic        mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = 0;
    logic        pc_load, busy;
    logic [31:0] pc_value;

    always #2.5 clk = ~clk;

    exc_seq u_exc_seq (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_vec(exc_vec),
        .priv_attempt(priv_attempt), .rte_req(rte_req), .instr_done(instr_done),
        .ret_pc(ret_pc), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_out(sr_out),
        .a7_we(a7_we), .a7_wdata(a7_wdata), .usp_acc(usp_acc), .a7_rdata(a7_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc_load(pc_load),
        .pc_value(pc_value), .busy(busy)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [15:0] data;
        string       rq;
    } bus_t;

    bus_t        exp_q[$];
    logic [31:0] pc_q[$];
    logic [15:0] mem [logic [31:0]];
    int checks = 0, fails = 0, ws = 0, wcnt = 0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic void push_bus(input logic we, input logic [31:0] a, input logic [15:0] d, input string rq);
        bus_t b;
        b.we = we; b.addr = a; b.data = d; b.rq = rq;
        exp_q.push_back(b);
    endfunction

    // scoreboard monitor: memory model + comparison
    always @(negedge clk) begin
        if (pc_load) begin
            if (pc_q.size() == 0) chk("R4 unexpected pc_load", pc_value, 32'hFFFF_FFFF);
            else chk("R4 handler/return pc", pc_value, pc_q.pop_front());
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt < ws) wcnt++;
            else begin
                wcnt = 0;
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected bus access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    bus_t e;
                    e = exp_q.pop_front();
                    chk({e.rq, " direction"}, {31'b0, mem_we}, {31'b0, e.we});
                    chk({e.rq, " address"}, mem_addr, e.addr);
                    if (e.we) chk({e.rq, " data"}, {16'b0, mem_wdata}, {16'b0, e.data});
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0;
                mem_ack = 1'b1;
            end
        end
    end

    task automatic exp_entry(input logic [31:0] sp, input logic [31:0] rpc, input logic [15:0] srw,
                             input logic [7:0] v, input logic [31:0] hpc, input string rq);
        logic [31:0] ta;
        ta = {22'b0, v, 2'b00};
        mem[ta] = hpc[31:16];
        mem[ta + 2] = hpc[15:0];
        push_bus(1, sp - 2, rpc[15:0], {rq, " R2 push low"});
        push_bus(1, sp - 4, rpc[31:16], {rq, " R2 push high"});
        push_bus(1, sp - 6, srw, {rq, " R3 push status"});
        push_bus(0, ta, 0, {rq, " R4 table high"});
        push_bus(0, ta + 2, 0, {rq, " R4 table low"});
        pc_q.push_back(hpc);
    endtask

    task automatic exp_rte(input logic [31:0] sp, input logic [31:0] rpc);
        push_bus(0, sp, 0, "R9 pop status");
        push_bus(0, sp + 2, 0, "R9 pop high");
        push_bus(0, sp + 4, 0, "R9 pop low");
        pc_q.push_back(rpc);
    endtask

    task automatic strobe(input logic e, input logic p, input logic r, input logic d,
                          input logic [7:0] v, input logic [31:0] rp);
        @(negedge clk);
        exc_req = e; priv_attempt = p; rte_req = r; instr_done = d; exc_vec = v; ret_pc = rp;
        @(negedge clk);
        exc_req = 0; priv_attempt = 0; rte_req = 0; instr_done = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        @(negedge clk);
        chk("R4 sequence finished", {31'b0, busy}, 32'h0);
    endtask

    task automatic set_sr(input logic [15:0] v);
        @(negedge clk); sr_wr = 1; sr_wdata = v;
        @(negedge clk); sr_wr = 0;
    endtask

    task automatic wr_a7(input logic [31:0] v, input logic ua);
        @(negedge clk); a7_we = 1; a7_wdata = v; usp_acc = ua;
        @(negedge clk); a7_we = 0; usp_acc = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL R11 watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status after reset", {16'b0, sr_out}, 32'h2700);
        chk("R1 idle after reset", {31'b0, busy}, 32'h0);
        chk("R1 R5 supervisor stack at reset", a7_rdata, 32'h1000);

        // R6 user copy via select in supervisor
        wr_a7(32'h0800, 1);
        usp_acc = 1; @(negedge clk);
        chk("R6 user copy readable", a7_rdata, 32'h0800);
        usp_acc = 0; @(negedge clk);
        chk("R5 supervisor copy active", a7_rdata, 32'h1000);

        // R12 status write masking
        set_sr(16'hFFFF); @(negedge clk);
        chk("R12 reserved bits read zero", {16'b0, sr_out}, 32'hA71F);
        set_sr(16'h2705); @(negedge clk);
        chk("R12 status write", {16'b0, sr_out}, 32'h2705);

        // R13 external exception, R2 R3 R4
        exp_entry(32'h1000, 32'h1234_5678, 16'h2705, 8'h40, 32'h0000_4000, "R13 ext");
        strobe(1, 0, 0, 0, 8'h40, 32'h1234_5678);
        wait_idle();
        chk("R3 status after entry", {16'b0, sr_out}, 32'h2705);
        chk("R2 stack after entry", a7_rdata, 32'h0FFA);

        // R9 return in supervisor
        exp_rte(32'h0FFA, 32'h1234_5678);
        strobe(0, 0, 1, 0, 0, 0);
        wait_idle();
        chk("R9 status restored", {16'b0, sr_out}, 32'h2705);
        chk("R9 stack restored", a7_rdata, 32'h1000);

        // R5 user state shows user copy
        set_sr(16'h0003); @(negedge clk);
        chk("R5 user copy active", a7_rdata, 32'h0800);
        wr_a7(32'h0900, 1);
        @(negedge clk);
        chk("R6 user-state write lands in user copy", a7_rdata, 32'h0900);

        // R8 privilege violation from user; R6 supervisor copy still 0x1000
        exp_entry(32'h1000, 32'h0000_2000, 16'h0003, 8'd8, 32'h0000_3000, "R8 priv R6");
        strobe(0, 1, 0, 0, 0, 32'h0000_2000);
        wait_idle();
        chk("R3 status after priv entry", {16'b0, sr_out}, 32'h2003);
        exp_rte(32'h0FFA, 32'h0000_2000);
        strobe(0, 0, 1, 0, 0, 0);
        wait_idle();
        chk("R9 back to user status", {16'b0, sr_out}, 32'h0003);
        chk("R9 user copy after return", a7_rdata, 32'h0900);

        // R10 return attempt in user state
        exp_entry(32'h1000, 32'h0000_2100, 16'h0003, 8'd8, 32'h0000_3000, "R10 rte in user");
        strobe(0, 0, 1, 0, 0, 32'h0000_2100);
        wait_idle();
        chk("R10 supervisor after violation", {16'b0, sr_out}, 32'h2003);
        exp_rte(32'h0FFA, 32'h0000_2100);
        strobe(0, 0, 1, 0, 0, 0);
        wait_idle();

        // R7 trace
        set_sr(16'h8004);
        exp_entry(32'h1000, 32'h0000_5000, 16'h8004, 8'd9, 32'h0000_6000, "R7 trace");
        strobe(0, 0, 0, 1, 0, 32'h0000_5000);
        wait_idle();
        chk("R7 trace clears T and sets S", {16'b0, sr_out}, 32'h2004);
        exp_rte(32'h0FFA, 32'h0000_5000);
        strobe(0, 0, 1, 0, 0, 0);
        wait_idle();
        chk("R9 trace bit restored", {16'b0, sr_out}, 32'h8004);

        // R8 priority over trace
        exp_entry(32'h1000, 32'h0000_5100, 16'h8004, 8'd8, 32'h0000_3000, "R8 priority");
        strobe(0, 1, 0, 1, 0, 32'h0000_5100);
        wait_idle();
        exp_rte(32'h0FFA, 32'h0000_5100);
        strobe(0, 0, 1, 0, 0, 0);
        wait_idle();

        // R13 trace over external
        exp_entry(32'h1000, 32'h0000_5200, 16'h8004, 8'd9, 32'h0000_6000, "R13 priority");
        strobe(1, 0, 0, 1, 8'h40, 32'h0000_5200);
        wait_idle();
        exp_rte(32'h0FFA, 32'h0000_5200);
        strobe(0, 0, 1, 0, 0, 0);
        wait_idle();
        set_sr(16'h2700);

        // R11 requests and status writes ignored while busy, with wait states
        ws = 2;
        exp_entry(32'h1000, 32'hAAAA_0000, 16'h2700, 8'h41, 32'h0000_7000, "R11 busy");
        strobe(1, 0, 0, 0, 8'h41, 32'hAAAA_0000);
        @(negedge clk);
        exc_req = 1; exc_vec = 8'h42; sr_wr = 1; sr_wdata = 16'h0000;
        @(negedge clk);
        exc_req = 0; sr_wr = 0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R11 status write ignored while busy", {16'b0, sr_out}, 32'h2700);
        chk("R11 no extra sequence", {31'b0, busy}, 32'h0);
        chk("R11 bus items left", exp_q.size(), 0);
        chk("R4 pc loads left", pc_q.size(), 0);
        finish_run();
    end
endmodule